// File: doc/BRIEF.md
# Split-Capacitor Redundant Sub-State Selector

Inside one module of a cascaded three-level clamped rectifier, each clock cycle carries a five-level output command for that module. Two of those levels, plus half and minus half of the module DC voltage, can each be produced in two redundant ways. One way draws on the upper capacitor and the other on the lower capacitor. This block decides which of the two redundant codes is used, so that the two capacitors of the split DC link stay at equal voltage.

The block takes three inputs: the level command, the sign of the line current, and two comparator flags that say which capacitor voltage is higher. It keeps one registered code for the positive half level and one for the negative half level. A register may take a new choice only on a clock edge where its own level is not being commanded. A run of identical half-level commands therefore never toggles between the two redundant codes, and the switching frequency does not rise. The per-module state leaves the block as the level together with a two-bit sub-state code.

Top module: `np_balance_sel`

## Requirements
- R1: `lvl_cmd` is a 3-bit two's-complement level with legal values +2, +1, 0, -1 and -2. `state_lvl` echoes `lvl_cmd` in the same cycle, with no register delay.
- R2: When `rst` is high at a rising clock edge, the positive-half code `sp_code` becomes 2'b00 and the negative-half code `sn_code` becomes 2'b10.
- R3: The flags are `c1_high`=1 with `c2_high`=0, meaning the upper capacitor is higher. On a rising edge where `lvl_cmd` is not +1, `sp_code` becomes 2'b01 when `i_pos`=1 (positive current) and 2'b00 when `i_pos`=0.
- R4: The flags are `c2_high`=1 with `c1_high`=0, meaning the lower capacitor is higher. On a rising edge where `lvl_cmd` is not +1, `sp_code` becomes 2'b00 when `i_pos`=1 and 2'b01 when `i_pos`=0.
- R5: On a rising edge where `lvl_cmd` is not -1, `sn_code` becomes 2'b11 in either of two cases: upper capacitor higher with `i_pos`=1, or lower capacitor higher with `i_pos`=0. In the two opposite cases it becomes 2'b10.
- R6: On any rising edge where `lvl_cmd` is +1, `sp_code` keeps its value. On any rising edge where `lvl_cmd` is -1, `sn_code` keeps its value.
- R7: When `c1_high` and `c2_high` are equal (both 0 for equal voltages, or both 1), neither code register changes.
- R8: `state_code` equals `sp_code` while `lvl_cmd` is +1 and equals `sn_code` while `lvl_cmd` is -1. For +2, 0 and -2 it is the fixed code 2'b00. This is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_cmd | input | 3 | Signed module level command, -2..+2 |
| i_pos | input | 1 | 1 when line current is positive, 0 when negative |
| c1_high | input | 1 | Upper capacitor voltage exceeds lower |
| c2_high | input | 1 | Lower capacitor voltage exceeds upper |
| sp_code | output | 2 | Held code for the positive half level |
| sn_code | output | 2 | Held code for the negative half level |
| state_lvl | output | 3 | Level field of the module state |
| state_code | output | 2 | Redundant sub-state field of the module state |

## Verification
A wrong choice in either code register shows on `sp_code` or `sn_code` one edge after the deciding inputs. It also shows on `state_code` in the same cycle as the matching half-level command, with no further delay. A broken hold shows as a code change within a run of +1 or -1 commands. The bench watches for this by demanding the opposite choice during every cycle of the run. A lost hold on equal voltages shows one edge after the comparator flags go equal.

// File: rtl/np_sel_pkg.sv
package np_sel_pkg;
    localparam int LVL_W  = 3;
    localparam int CODE_W = 2;

    typedef logic signed [LVL_W-1:0] lvl_t;
    typedef logic [CODE_W-1:0]       code_t;

    localparam lvl_t  LVL_HALF_POS = lvl_t'(1);
    localparam lvl_t  LVL_HALF_NEG = lvl_t'(-1);
    localparam code_t FIXED_CODE   = '0;

    typedef enum logic [1:0] {
        CMP_EVEN  = 2'd0,
        CMP_UPPER = 2'd1,
        CMP_LOWER = 2'd2
    } cmp_t;

    typedef struct packed {
        lvl_t  lvl;
        code_t code;
    } mod_state_t;

    function automatic cmp_t decode_cmp(input logic up_hi, input logic lo_hi);
        if (up_hi && !lo_hi)      return CMP_UPPER;
        else if (lo_hi && !up_hi) return CMP_LOWER;
        else                      return CMP_EVEN;
    endfunction

    // Low bit of the redundant code: 1 selects the alternate capacitor path
    function automatic logic alt_path(input cmp_t c, input logic cur_pos);
        return (c == CMP_UPPER) == cur_pos;
    endfunction
endpackage

// File: rtl/np_cmp_decode.sv
module np_cmp_decode
    import np_sel_pkg::*;
(
    input  logic c1_high,
    input  logic c2_high,
    input  logic i_pos,
    output logic decisive,
    output logic alt
);
    cmp_t cmp;

    always_comb begin
        cmp      = decode_cmp(c1_high, c2_high);
        decisive = (cmp != CMP_EVEN);
        alt      = alt_path(cmp, i_pos);
    end
endmodule

// File: rtl/np_hold_reg.sv
module np_hold_reg
    import np_sel_pkg::*;
#(
    parameter logic  PREFIX     = 1'b0,
    parameter lvl_t  HOLD_LVL   = LVL_HALF_POS,
    parameter code_t RESET_CODE = 2'b00
) (
    input  logic  clk,
    input  logic  rst,
    input  lvl_t  lvl,
    input  logic  decisive,
    input  logic  alt,
    output code_t code_q
);
    logic reload;

    assign reload = (lvl != HOLD_LVL) && decisive;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= RESET_CODE;
        else if (reload)
            code_q <= {PREFIX, alt};
    end

    // R2
    reset_code_chk: assert property (@(posedge clk) rst |=> code_q == RESET_CODE);

    // R6
    hold_in_use_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl == HOLD_LVL) |=> $stable(code_q));

    // R7
    hold_even_chk: assert property (@(posedge clk) disable iff (rst)
        !decisive |=> $stable(code_q));

    // R3
    prefix_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        code_q[1] == PREFIX);

    // R5
    reload_take_chk: assert property (@(posedge clk) disable iff (rst)
        ((lvl != HOLD_LVL) && decisive) |=> code_q[0] == $past(alt));
endmodule

// File: rtl/np_state_mux.sv
module np_state_mux
    import np_sel_pkg::*;
(
    input  lvl_t       lvl,
    input  code_t      sp,
    input  code_t      sn,
    output mod_state_t st
);
    always_comb begin
        st.lvl = lvl;
        unique case (lvl)
            LVL_HALF_POS: st.code = sp;
            LVL_HALF_NEG: st.code = sn;
            default:      st.code = FIXED_CODE;
        endcase
    end
endmodule

// File: rtl/np_balance_sel.sv
module np_balance_sel
    import np_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] lvl_cmd,
    input  logic             i_pos,
    input  logic             c1_high,
    input  logic             c2_high,
    output logic [CODE_W-1:0] sp_code,
    output logic [CODE_W-1:0] sn_code,
    output logic [LVL_W-1:0] state_lvl,
    output logic [CODE_W-1:0] state_code
);
    localparam int NREG = 2;

    lvl_t       lvl;
    logic       decisive;
    logic       alt;
    code_t      codes [NREG];
    mod_state_t st;

    assign lvl = lvl_t'(lvl_cmd);

    np_cmp_decode u_cmp (
        .c1_high (c1_high),
        .c2_high (c2_high),
        .i_pos   (i_pos),
        .decisive(decisive),
        .alt     (alt)
    );

    // index 0: positive half level, index 1: negative half level
    for (genvar g = 0; g < NREG; g++) begin : g_hold
        np_hold_reg #(
            .PREFIX    (g == 1),
            .HOLD_LVL  ((g == 0) ? LVL_HALF_POS : LVL_HALF_NEG),
            .RESET_CODE((g == 0) ? code_t'(2'b00) : code_t'(2'b10))
        ) u_hold (
            .clk     (clk),
            .rst     (rst),
            .lvl     (lvl),
            .decisive(decisive),
            .alt     (alt),
            .code_q  (codes[g])
        );
    end

    np_state_mux u_mux (
        .lvl(lvl),
        .sp (codes[0]),
        .sn (codes[1]),
        .st (st)
    );

    assign sp_code    = codes[0];
    assign sn_code    = codes[1];
    assign state_lvl  = st.lvl;
    assign state_code = st.code;

    // R8
    half_pos_route_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_HALF_POS) |-> state_code == sp_code);

    // R8
    half_neg_route_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_HALF_NEG) |-> state_code == sn_code);

    // R8
    fixed_code_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != LVL_HALF_POS && lvl != LVL_HALF_NEG) |-> state_code == FIXED_CODE);

    // R1
    lvl_echo_chk: assert property (@(posedge clk) state_lvl == lvl_cmd);
endmodule

// File: tb/np_balance_sel_bench.sv
module np_balance_sel_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] lvl_cmd;
    logic       i_pos, c1_high, c2_high;
    logic [1:0] sp_code, sn_code, state_code;
    logic [2:0] state_lvl;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    np_balance_sel u_np_balance_sel (
        .clk(clk), .rst(rst), .lvl_cmd(lvl_cmd), .i_pos(i_pos),
        .c1_high(c1_high), .c2_high(c2_high), .sp_code(sp_code),
        .sn_code(sn_code), .state_lvl(state_lvl), .state_code(state_code)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input int lvl, input logic ip, input logic h1, input logic h2);
        lvl_cmd = 3'(lvl);
        i_pos   = ip;
        c1_high = h1;
        c2_high = h2;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(0, 1'b1, 1'b1, 1'b0);
        tick();
        tick();
        chk("R2 sp after reset", {1'b0, sp_code}, 3'b000);
        chk("R2 sn after reset", {1'b0, sn_code}, 3'b010);
        chk("R8 fixed code at 0", {1'b0, state_code}, 3'b000);
        rst = 1'b0;
    endtask

    task automatic t_select();
        drive(0, 1'b1, 1'b1, 1'b0); tick();
        chk("R3 sp upper hi pos", {1'b0, sp_code}, 3'b001);
        chk("R5 sn upper hi pos", {1'b0, sn_code}, 3'b011);
        drive(0, 1'b0, 1'b1, 1'b0); tick();
        chk("R3 sp upper hi neg", {1'b0, sp_code}, 3'b000);
        chk("R5 sn upper hi neg", {1'b0, sn_code}, 3'b010);
        drive(2, 1'b0, 1'b0, 1'b1); tick();
        chk("R4 sp lower hi neg", {1'b0, sp_code}, 3'b001);
        chk("R5 sn lower hi neg", {1'b0, sn_code}, 3'b011);
        drive(-2, 1'b1, 1'b0, 1'b1); tick();
        chk("R4 sp lower hi pos", {1'b0, sp_code}, 3'b000);
        chk("R5 sn lower hi pos", {1'b0, sn_code}, 3'b010);
    endtask

    task automatic t_hold_sp();
        drive(0, 1'b1, 1'b1, 1'b0); tick();
        chk("R3 sp set before run", {1'b0, sp_code}, 3'b001);
        for (int k = 0; k < 4; k++) begin
            drive(1, 1'b0, 1'b1, 1'b0);
            #1;
            chk("R8 state follows sp", {1'b0, state_code}, 3'b001);
            tick();
            chk("R6 sp held at +1", {1'b0, sp_code}, 3'b001);
            chk("R5 sn moves during +1", {1'b0, sn_code}, 3'b010);
        end
        drive(0, 1'b0, 1'b1, 1'b0); tick();
        chk("R3 sp reloads after run", {1'b0, sp_code}, 3'b000);
    endtask

    task automatic t_hold_sn();
        drive(0, 1'b1, 1'b0, 1'b1); tick();
        chk("R5 sn set before run", {1'b0, sn_code}, 3'b010);
        for (int k = 0; k < 4; k++) begin
            drive(-1, 1'b0, 1'b0, 1'b1);
            #1;
            chk("R8 state follows sn", {1'b0, state_code}, 3'b010);
            chk("R1 level echo -1", state_lvl, 3'b111);
            tick();
            chk("R6 sn held at -1", {1'b0, sn_code}, 3'b010);
            chk("R4 sp moves during -1", {1'b0, sp_code}, 3'b001);
        end
        drive(2, 1'b0, 1'b0, 1'b1); tick();
        chk("R5 sn reloads after run", {1'b0, sn_code}, 3'b011);
    endtask

    task automatic t_even();
        drive(0, 1'b1, 1'b1, 1'b0); tick();
        drive(0, 1'b0, 1'b0, 1'b0); tick();
        chk("R7 sp held equal", {1'b0, sp_code}, 3'b001);
        chk("R7 sn held equal", {1'b0, sn_code}, 3'b011);
        drive(0, 1'b0, 1'b1, 1'b1); tick();
        chk("R7 sp held both flags", {1'b0, sp_code}, 3'b001);
        chk("R7 sn held both flags", {1'b0, sn_code}, 3'b011);
    endtask

    task automatic t_fixed();
        drive(2, 1'b0, 1'b0, 1'b0); #1;
        chk("R8 fixed code at +2", {1'b0, state_code}, 3'b000);
        chk("R1 level echo +2", state_lvl, 3'b010);
        drive(-2, 1'b0, 1'b0, 1'b0); #1;
        chk("R8 fixed code at -2", {1'b0, state_code}, 3'b000);
        chk("R1 level echo -2", state_lvl, 3'b110);
        drive(1, 1'b0, 1'b0, 1'b0); #1;
        chk("R8 state at +1", {1'b0, state_code}, 3'b001);
        tick();
    endtask

    initial begin
        drive(0, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_hold_sp();
        t_hold_sn();
        t_even();
        t_fixed();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule